// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Generator

This block drives four pulse-width-modulated outputs from one slow, fixed-rate tick pulse (nominally one pulse per microsecond). Each channel has its own period, duty and mode settings. The mode settings pick a power-of-two slow-down of the tick and the output polarity. Software programs the channels through a plain synchronous port with address, write data and write strobe, and reads the settings back through a registered data output.

Every setting is first captured in a shadow copy. The running waveform keeps its old settings until software writes the period register of that channel. After that write, the new set is taken over as a whole at the end of the period that is running. So a changed duty or divider never gives a partial or mixed period. If the channel is idle, writing a nonzero period starts it at once. Writing a period of zero stops the channel after its current period. From then on the output stays low, whatever the polarity setting holds.

Top module: `pwmsh_top`

## Requirements
- R1: After reset every output is low and every period, duty and mode register reads back as zero.
- R2: Per channel `c` (0 to 3), the period register sits at 0x400+4c, the duty register at 0x420+4c and the mode register at 0x440+4c. Period and duty read back all 16 written bits. Mode reads back only bits [1:0] and bit 5, and all other bits read as zero. Unmapped addresses read zero. Read data appears on the clock edge after the address is presented.
- R3: With non-inverted polarity, an active channel drives high for `duty` counts and low for `period - duty` counts in each period. A duty of 0 gives a constant low, and a duty at or above the period gives a constant high.
- R4: Mode bits [1:0] = n make each count last 2^n tick pulses, so every period lasts exactly `period * 2^n` tick pulses.
- R5: Writing a nonzero period to an idle channel loads all its shadow settings. The new period then starts from count zero, and the output shows its first level by the second clock edge after the write edge.
- R6: On a running channel, duty and mode writes leave the running waveform unchanged until the period register is written. After that write, the new settings take effect together at the next period boundary.
- R7: Writing zero to the period register of a running channel lets the running period finish in full. After that the output stays low continuously.
- R8: Mode bit 5 = 1 inverts the output during active periods. A disabled channel is low regardless of bit 5.
- R9: Channels run independently: programming or stopping one channel does not alter another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at the fixed counting rate |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| pwm_out | output | 4 | Channel outputs, bit c for channel c |

## Verification
Some properties are checked on every cycle:
- the count stays below the active period;
- the prescaler phase stays within the selected divider;
- active settings change only at a period boundary;
- a channel stops only on the last count of a period;
- a period starts with count and phase at zero;
- the address decode selects at most one register;
- a period write is captured exactly.

The exact high and low lengths come only from the directed scenarios. So do the delayed take-over of shadowed writes, the completion of a period before a stop, polarity inversion, constant-level duties and independence between channels. These scenarios time the outputs against tick counts worked out from the requirements.

// File: rtl/pwmsh_pkg.sv
package pwmsh_pkg;

   // Which register of a channel an address selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PRD  = 2'd1,
      SEL_DUT  = 2'd2,
      SEL_MODE = 2'd3
   } reg_sel_e;

   // Default register map of the block
   localparam int unsigned PRD_BASE_DEF  = 32'h400;
   localparam int unsigned DUT_BASE_DEF  = 32'h420;
   localparam int unsigned MODE_BASE_DEF = 32'h440;
   localparam int unsigned STRIDE_DEF    = 4;
   localparam int unsigned POL_BIT_DEF   = 5;

   // Mask of (2**sel - 1) for a prescaler limit
   function automatic int unsigned pre_mask(input int unsigned sel);
      return (32'd1 << sel) - 32'd1;
   endfunction

endpackage

// File: rtl/pwmsh_regs.sv
module pwmsh_regs
   import pwmsh_pkg::*;
#(
   parameter int unsigned NCH       = 4,
   parameter int unsigned CW        = 16,
   parameter int unsigned DIVW      = 2,
   parameter int unsigned AW        = 12,
   parameter int unsigned DW        = 32,
   parameter int unsigned PRD_BASE  = PRD_BASE_DEF,
   parameter int unsigned DUT_BASE  = DUT_BASE_DEF,
   parameter int unsigned MODE_BASE = MODE_BASE_DEF,
   parameter int unsigned STRIDE    = STRIDE_DEF,
   parameter int unsigned POL_BIT   = POL_BIT_DEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [AW-1:0]            addr,
   input  logic [DW-1:0]            wdata,
   input  logic                     we,
   output logic [DW-1:0]            rdata,
   output logic [NCH-1:0][CW-1:0]   sh_prd,
   output logic [NCH-1:0][CW-1:0]   sh_dut,
   output logic [NCH-1:0][DIVW-1:0] sh_div,
   output logic [NCH-1:0]           sh_pol,
   output logic [NCH-1:0]           prd_wr
);

   localparam int unsigned SPAN = NCH * STRIDE;

   // Elaboration-time parameter checks
   if (CW < 2 || CW > DW) begin : g_bad_cw
      $error("pwmsh_regs: CW must lie in 2..DW");
   end
   if (POL_BIT < DIVW || POL_BIT >= DW) begin : g_bad_pol
      $error("pwmsh_regs: POL_BIT must sit above the divider field and inside DW");
   end
   if (DUT_BASE < PRD_BASE + SPAN || MODE_BASE < DUT_BASE + SPAN) begin : g_bad_map
      $error("pwmsh_regs: register regions overlap");
   end
   if (MODE_BASE + SPAN > (1 << AW)) begin : g_bad_aw
      $error("pwmsh_regs: AW too narrow for the register map");
   end

   logic [NCH-1:0] hit_prd, hit_dut, hit_mode;
   reg_sel_e [NCH-1:0] sel;
   logic unused_wbits;

   assign unused_wbits = ^wdata;

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         assign hit_prd[c]  = (addr == AW'(PRD_BASE  + STRIDE * c));
         assign hit_dut[c]  = (addr == AW'(DUT_BASE  + STRIDE * c));
         assign hit_mode[c] = (addr == AW'(MODE_BASE + STRIDE * c));
         assign prd_wr[c]   = we & hit_prd[c];

         always_comb begin
            sel[c] = SEL_NONE;
            if (hit_prd[c])  sel[c] = SEL_PRD;
            if (hit_dut[c])  sel[c] = SEL_DUT;
            if (hit_mode[c]) sel[c] = SEL_MODE;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_prd[c] <= '0;
               sh_dut[c] <= '0;
               sh_div[c] <= '0;
               sh_pol[c] <= 1'b0;
            end else if (we) begin
               unique case (sel[c])
                  SEL_PRD:  sh_prd[c] <= wdata[CW-1:0];
                  SEL_DUT:  sh_dut[c] <= wdata[CW-1:0];
                  SEL_MODE: begin
                     sh_div[c] <= wdata[DIVW-1:0];
                     sh_pol[c] <= wdata[POL_BIT];
                  end
                  default: ;
               endcase
            end
         end

         // R2: a period write is captured exactly
         a_r2_prd_capture: assert property (@(posedge clk) disable iff (!rst_n)
            $past(prd_wr[c]) |-> sh_prd[c] == $past(wdata[CW-1:0]));
      end
   endgenerate

   // Read mux, registered
   logic [DW-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NCH; i++) begin
         if (hit_prd[i]) rd_next = DW'(sh_prd[i]);
         if (hit_dut[i]) rd_next = DW'(sh_dut[i]);
         if (hit_mode[i]) begin
            rd_next = DW'(sh_div[i]);
            rd_next[POL_BIT] = sh_pol[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_next;
   end

   // R2: the decode never selects two registers at once
   a_r2_decode_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_prd, hit_dut, hit_mode}));

endmodule

// File: rtl/pwmsh_chan.sv
module pwmsh_chan
   import pwmsh_pkg::*;
#(
   parameter int unsigned CW   = 16,
   parameter int unsigned DIVW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            prd_wr,
   input  logic [CW-1:0]   sh_prd,
   input  logic [CW-1:0]   sh_dut,
   input  logic [DIVW-1:0] sh_div,
   input  logic            sh_pol,
   output logic            pwm
);

   // Largest divider exponent is 2**DIVW-1, so the phase needs that many bits
   localparam int unsigned PREW = (1 << DIVW) - 1;

   if (DIVW < 1 || DIVW > 3) begin : g_bad_divw
      $error("pwmsh_chan: DIVW must lie in 1..3");
   end

   logic            arm;
   logic            running;
   logic [CW-1:0]   cnt;
   logic [PREW-1:0] pre;
   logic [CW-1:0]   act_prd;
   logic [CW-1:0]   act_dut;
   logic [DIVW-1:0] act_div;
   logic            act_pol;

   logic [PREW-1:0] pre_lim;
   logic            dtick;
   logic            last;
   logic            take;

   assign pre_lim = PREW'(pre_mask(32'(act_div)));
   assign dtick   = running & tick & (pre == pre_lim);
   assign last    = dtick & (cnt == act_prd - CW'(1));
   // Shadow set is taken either at idle or at a period boundary
   assign take    = arm & (!running | last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm     <= 1'b0;
         running <= 1'b0;
         cnt     <= '0;
         pre     <= '0;
         act_prd <= '0;
         act_dut <= '0;
         act_div <= '0;
         act_pol <= 1'b0;
      end else begin
         if (take) begin
            arm     <= 1'b0;
            act_prd <= sh_prd;
            act_dut <= sh_dut;
            act_div <= sh_div;
            act_pol <= sh_pol;
            running <= (sh_prd != '0);
            cnt     <= '0;
            pre     <= '0;
         end else if (running && tick) begin
            if (pre == pre_lim) begin
               pre <= '0;
               cnt <= last ? '0 : cnt + CW'(1);
            end else begin
               pre <= pre + PREW'(1);
            end
         end
         if (prd_wr) arm <= 1'b1;
      end
   end

   assign pwm = running & ((cnt < act_dut) ^ act_pol);

   // R3: the count never reaches the active period
   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt < act_prd);

   // R4: the prescaler phase stays inside the selected divider
   a_r4_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> pre <= pre_lim);

   // R5: every period starts at count and phase zero
   a_r5_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (cnt == '0) && (pre == '0));

   // R6: active settings move only at a boundary
   a_r6_atomic_take: assert property (@(posedge clk) disable iff (!rst_n)
      $past(running) && !$past(last) |->
         $stable(act_dut) && $stable(act_div) && $stable(act_pol) && $stable(act_prd));

   // R7: a stop happens only on the last count of a period
   a_r7_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(last));

endmodule

// File: rtl/pwmsh_top.sv
module pwmsh_top
   import pwmsh_pkg::*;
#(
   parameter int unsigned NCH     = 4,
   parameter int unsigned CW      = 16,
   parameter int unsigned DIVW    = 2,
   parameter int unsigned AW      = 12,
   parameter int unsigned DW      = 32,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   input  logic           bus_we,
   output logic [DW-1:0]  bus_rdata,
   output logic [NCH-1:0] pwm_out
);

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("pwmsh_top: NCH must lie in 1..8");
   end

   logic [NCH-1:0][CW-1:0]   sh_prd;
   logic [NCH-1:0][CW-1:0]   sh_dut;
   logic [NCH-1:0][DIVW-1:0] sh_div;
   logic [NCH-1:0]           sh_pol;
   logic [NCH-1:0]           prd_wr;
   logic [NCH-1:0]           pwm_raw;

   pwmsh_regs #(
      .NCH(NCH), .CW(CW), .DIVW(DIVW), .AW(AW), .DW(DW)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .we     (bus_we),
      .rdata  (bus_rdata),
      .sh_prd (sh_prd),
      .sh_dut (sh_dut),
      .sh_div (sh_div),
      .sh_pol (sh_pol),
      .prd_wr (prd_wr)
   );

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_chan
         pwmsh_chan #(.CW(CW), .DIVW(DIVW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .prd_wr (prd_wr[c]),
            .sh_prd (sh_prd[c]),
            .sh_dut (sh_dut[c]),
            .sh_div (sh_div[c]),
            .sh_pol (sh_pol[c]),
            .pwm    (pwm_raw[c])
         );
      end

      if (REG_OUT) begin : g_out_ff
         always_ff @(posedge clk) begin
            if (!rst_n) pwm_out <= '0;
            else        pwm_out <= pwm_raw;
         end
      end else begin : g_out_comb
         assign pwm_out = pwm_raw;
      end
   endgenerate

endmodule

// File: tb/sim_pwmsh_top.sv
`timescale 1ns/1ps
module sim_pwmsh_top;

   localparam int TK = 4;  // clocks per tick pulse

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pwmsh_top u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   initial begin
      forever begin
         repeat (TK - 1) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   function automatic logic [11:0] aprd(input int ch);  return 12'(32'h400 + 4 * ch); endfunction
   function automatic logic [11:0] adut(input int ch);  return 12'(32'h420 + 4 * ch); endfunction
   function automatic logic [11:0] amode(input int ch); return 12'(32'h440 + 4 * ch); endfunction

   // Time one high phase and the following low phase, in clocks
   task automatic measure(input int ch, output int hi, output int lo);
      int t;
      hi = 0; lo = 0;
      t = 0; while (pwm_out[ch] !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
      t = 0; while (pwm_out[ch] !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
      while (pwm_out[ch] === 1'b1 && hi < 4000) begin @(negedge clk); hi++; end
      while (pwm_out[ch] === 1'b0 && lo < 4000) begin @(negedge clk); lo++; end
   endtask

   // Check that a channel holds one level for n clocks
   task automatic hold(input string tag, input int ch, input logic lvl, input int n);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out[ch] !== lvl) bad++;
         @(negedge clk);
      end
      chk(tag, 32'(bad), 32'd0);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 outputs low after reset", 32'(pwm_out), 32'd0);
      rd(aprd(0), d);  chk("R1 period reads zero", d, 32'd0);
      rd(adut(2), d);  chk("R1 duty reads zero", d, 32'd0);
      rd(amode(3), d); chk("R1 mode reads zero", d, 32'd0);
   endtask

   task automatic t_readback;
      logic [31:0] d;
      wr(adut(3), 32'hFFFF_1234);
      wr(amode(3), 32'hFFFF_FFFF);
      rd(adut(3), d);  chk("R2 duty readback 16 bits", d, 32'h1234);
      rd(amode(3), d); chk("R2 mode readback bits 1:0 and 5", d, 32'h23);
      rd(12'h004, d);  chk("R2 unmapped reads zero", d, 32'd0);
      chk("R2 no period write, ch3 idle", 32'(pwm_out[3]), 32'd0);
   endtask

   task automatic t_enable;
      int hi, lo;
      logic [31:0] d;
      wr(amode(0), 32'h0);
      wr(adut(0), 32'd3);
      wr(aprd(0), 32'd10);
      @(negedge clk);
      chk("R5 output high two edges after enable", 32'(pwm_out[0]), 32'd1);
      measure(0, hi, lo);
      chk("R3 high length dut=3", 32'(hi), 32'(3 * TK));
      chk("R3 low length prd=10", 32'(lo), 32'(7 * TK));
      rd(aprd(0), d); chk("R2 period readback", d, 32'd10);
   endtask

   task automatic t_shadow;
      int hi, lo;
      wr(adut(0), 32'd7);
      measure(0, hi, lo); measure(0, hi, lo);
      chk("R6 duty write alone held in shadow (hi)", 32'(hi), 32'(3 * TK));
      chk("R6 duty write alone held in shadow (lo)", 32'(lo), 32'(7 * TK));
      wr(aprd(0), 32'd10);
      measure(0, hi, lo); measure(0, hi, lo);
      chk("R6 new duty after period write (hi)", 32'(hi), 32'(7 * TK));
      chk("R6 new duty after period write (lo)", 32'(lo), 32'(3 * TK));
   endtask

   task automatic t_div;
      int hi, lo;
      wr(amode(1), 32'h2);
      wr(adut(1), 32'd2);
      wr(aprd(1), 32'd5);
      measure(1, hi, lo);
      chk("R4 divide by 4 high", 32'(hi), 32'(2 * 4 * TK));
      chk("R4 divide by 4 low", 32'(lo), 32'(3 * 4 * TK));
      measure(0, hi, lo);
      chk("R9 ch0 unchanged while ch1 runs", 32'(hi), 32'(7 * TK));
   endtask

   task automatic t_pol;
      int hi, lo;
      wr(amode(2), 32'h20);
      wr(adut(2), 32'd1);
      wr(aprd(2), 32'd4);
      measure(2, hi, lo);
      chk("R8 inverted high length", 32'(hi), 32'(3 * TK));
      chk("R8 inverted low length", 32'(lo), 32'(1 * TK));
   endtask

   task automatic t_extremes;
      wr(adut(1), 32'd0);
      wr(aprd(1), 32'd5);
      repeat (200) @(negedge clk);
      hold("R3 duty zero constant low", 1, 1'b0, 200);
      wr(adut(1), 32'hFFFF);
      wr(aprd(1), 32'd5);
      repeat (200) @(negedge clk);
      hold("R3 duty above period constant high", 1, 1'b1, 200);
   endtask

   task automatic t_disable;
      int hi, t;
      t = 0; while (pwm_out[0] !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
      t = 0; while (pwm_out[0] !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
      wr(aprd(0), 32'd0);
      hi = 1;
      while (pwm_out[0] === 1'b1 && hi < 4000) begin @(negedge clk); hi++; end
      chk("R7 running period finishes after stop", 32'(hi), 32'(7 * TK));
      hold("R7 output low after stop", 0, 1'b0, 300);
      chk("R9 ch1 still high after ch0 stop", 32'(pwm_out[1]), 32'd1);
      wr(aprd(2), 32'd0);
      repeat (100) @(negedge clk);
      hold("R8 inverted channel low when disabled", 2, 1'b0, 100);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_enable();
      t_shadow();
      t_div();
      t_pol();
      t_extremes();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule